// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and arbitrates five interrupt inputs. One input is non-maskable. The other four are maskable: a second timer, a vertical-sync signal, a first timer and a power-fail input. Every input first passes through a two-flop synchronizer. An edge event latches a pending flag. When the block may present a request, it raises `irq_o` together with the identity of the winning source and that source's 12-bit program-memory vector address. The core accepts the request with a one-cycle `ack_i`. Accepting a request clears the pending flag of that source only and marks a service routine as active. A one-cycle `reti_i` strobe ends the innermost active routine.

Maskable routines never nest. The non-maskable source may preempt any routine, and its return brings back the service state that was in force when it was taken. An 8-bit option register can only be written, and only as a whole byte at data address 0xC8. It holds a global enable for the maskable sources. It also holds the trigger selects for the second-timer input (falling edge or low level) and the sync input (falling or rising edge).

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o`, `in_service_o` and `nmi_active_o` are 0 and `vec_addr_o` is 0. Every option field is 0, so maskable sources are blocked and the second timer is in edge mode.
- R2: The vector address follows the source id: id 0 (non-maskable) gives 0xFFC, id 1 (timer 2) 0xFF6, id 2 (sync) 0xFF4, id 3 (timer 1) 0xFF2 and id 4 (power) 0xFF0. While `irq_o` is 0, `vec_addr_o` and `vec_id_o` read 0.
- R3: When several sources request together, id 0 wins. Among the maskable sources, id 1 beats 2, 2 beats 3 and 3 beats 4.
- R4: Option bit 6 is the global enable. While it is 0, no maskable source is presented, but their pending flags stay latched. The non-maskable source is still presented.
- R5: No maskable request is presented while a maskable routine is in service or a non-maskable routine is active. A `reti_i` outside a non-maskable routine ends maskable service.
- R6: A non-maskable request is presented even while a maskable routine is in service. It is not presented again while its own routine is active. Its `reti_i` clears `nmi_active_o` and leaves `in_service_o` as it was.
- R7: Option bit 5 set to 1 makes timer 2 request on a low input level, without latching, so the level is sampled again after every return. Set to 0, the source requests once per falling edge.
- R8: Option bit 4 selects the edge for the sync input: 1 selects the rising edge and 0 the falling edge. A change in the opposite direction makes no request.
- R9: The option register is written only when `cfg_we_i` is 1 and `cfg_addr_i` is 0xC8. Bits 7 and 3..0 of the written byte have no effect.
- R10: `ack_i` with `irq_o` high clears the pending flag of the presented source only. `ack_i` with `irq_o` low has no effect.
- R11: A falling edge on the non-maskable, timer or power input produces exactly one request, which is visible within four clock cycles of the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n_i | input | 1 | Non-maskable input, active on falling edge |
| tmr2_n_i | input | 1 | Timer 2 input (id 1) |
| vsync_i | input | 1 | Vertical-sync input (id 2) |
| tmr1_n_i | input | 1 | Timer 1 input (id 3) |
| pwr_n_i | input | 1 | Power-fail input (id 4) |
| cfg_we_i | input | 1 | Data write strobe |
| cfg_addr_i | input | 8 | Data write address |
| cfg_wdata_i | input | 8 | Data write byte |
| ack_i | input | 1 | Core accepts the presented request |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Request to the core |
| vec_id_o | output | 3 | Id of the presented source |
| vec_addr_o | output | 12 | Vector address of the presented source |
| in_service_o | output | 1 | A maskable routine is active |
| nmi_active_o | output | 1 | A non-maskable routine is active |

## Verification
The bench fires several sources at once and then drains them. It checks that they come out in strict id order and that the number of accepted requests equals the number of sources fired. A design that cleared every pending flag on one acknowledge, or that ordered the sources wrongly, fails these checks. It takes a non-maskable request in the middle of a maskable routine and then checks each return. A design that dropped maskable service on the non-maskable return, or that let a maskable source nest, presents a request at the wrong moment. It holds timer 2 low in level mode and in edge mode, and holds the sync input in the deselected direction. A latched level request, or a wrong edge select, shows up as a missing or extra request. It also writes to a neighbouring address and writes the unused bits, to confirm that neither changes the enable.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NSRC = 5;
  localparam int IDW  = 3;
  localparam int AW   = 12;
  localparam int NMSK = NSRC - 1;

  // vector address: id 0 sits at the top slot, the others step down by two
  function automatic logic [AW-1:0] vector_of(input logic [IDW-1:0] id);
    if (id == '0) return 12'hFFC;
    return 12'hFF8 - {8'h00, id, 1'b0};
  endfunction

  // lowest-numbered maskable request wins; bit k of r is id k+1; 0 = none
  function automatic logic [IDW-1:0] pick_first(input logic [NMSK-1:0] r);
    logic [IDW-1:0] id;
    id = '0;
    for (int i = NMSK - 1; i >= 0; i--)
      if (r[i]) id = IDW'(i + 1);
    return id;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic rise_sel_i,
  output logic low_o,
  output logic edge_o
);
  logic ff1_q, ff2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ff1_q  <= RST_VAL;
      ff2_q  <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      ff1_q  <= async_i;
      ff2_q  <= ff1_q;
      prev_q <= ff2_q;
    end
  end

  assign low_o  = ~ff2_q;
  assign edge_o = rise_sel_i ? (~prev_q & ff2_q) : (prev_q & ~ff2_q);
endmodule

// File: rtl/irq_opt_reg.sv
module irq_opt_reg #(
  parameter int          DW   = 8,
  parameter logic [7:0]  ADDR = 8'hC8,
  parameter int          GEN_BIT = 6,
  parameter int          LVL_BIT = 5,
  parameter int          RISE_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          gen_o,
  output logic          lvl1_o,
  output logic          rise2_o
);
  logic hit;
  logic unused_bits;

  assign hit = we_i && (addr_i == ADDR);
  assign unused_bits = ^{wdata_i[DW-1], wdata_i[RISE_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_o   <= 1'b0;
      lvl1_o  <= 1'b0;
      rise2_o <= 1'b0;
    end else if (hit) begin
      gen_o   <= wdata_i[GEN_BIT];
      lvl1_o  <= wdata_i[LVL_BIT];
      rise2_o <= wdata_i[RISE_BIT];
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] edge_i,
  input  logic [NSRC-1:0] low_i,
  input  logic [NSRC-1:0] lvl_mode_i,
  input  logic            gen_i,
  input  logic            ack_i,
  input  logic            reti_i,
  output logic            irq_o,
  output logic [IDW-1:0]  vec_id_o,
  output logic [AW-1:0]   vec_addr_o,
  output logic            in_service_o,
  output logic            nmi_active_o,
  output logic            take_o
);
  logic [NSRC-1:0] pend_q, req, clr;
  logic            svc_q, nmi_q;
  logic            nmi_go, mask_ok, mask_go;
  logic [IDW-1:0]  win_id;

  assign req     = (lvl_mode_i & low_i) | (~lvl_mode_i & pend_q);
  assign nmi_go  = req[0] & ~nmi_q;
  assign mask_ok = gen_i & ~svc_q & ~nmi_q;
  assign win_id  = pick_first(req[NSRC-1:1]);
  assign mask_go = mask_ok & (win_id != '0);

  assign irq_o      = nmi_go | mask_go;
  assign vec_id_o   = nmi_go ? '0 : (mask_go ? win_id : '0);
  assign vec_addr_o = irq_o ? vector_of(vec_id_o) : '0;
  assign take_o     = ack_i & irq_o;
  assign clr        = take_o ? (NSRC'(1) << vec_id_o) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      svc_q  <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | edge_i;
      if (take_o && vec_id_o == '0)       nmi_q <= 1'b1;
      else if (reti_i && nmi_q)           nmi_q <= 1'b0;
      if (take_o && vec_id_o != '0)       svc_q <= 1'b1;
      else if (reti_i && !nmi_q)          svc_q <= 1'b0;
    end
  end

  assign in_service_o = svc_q;
  assign nmi_active_o = nmi_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_n_i,
  input  logic        tmr2_n_i,
  input  logic        vsync_i,
  input  logic        tmr1_n_i,
  input  logic        pwr_n_i,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [7:0]  cfg_wdata_i,
  input  logic        ack_i,
  input  logic        reti_i,
  output logic        irq_o,
  output logic [2:0]  vec_id_o,
  output logic [11:0] vec_addr_o,
  output logic        in_service_o,
  output logic        nmi_active_o
);
  localparam int SYNC_ID = 2;
  localparam int LVL_ID  = 1;

  logic [NSRC-1:0] raw, low, edge_ev, lvl_mode;
  logic            gen, lvl1, rise2, take;

  assign raw = {pwr_n_i, tmr1_n_i, vsync_i, tmr2_n_i, nmi_n_i};

  irq_opt_reg u_opt (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .gen_o(gen), .lvl1_o(lvl1), .rise2_o(rise2)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic rsel;
    if (g == SYNC_ID) begin : g_sel
      assign rsel = rise2;
    end else begin : g_fix
      assign rsel = 1'b0;
    end
    assign lvl_mode[g] = (g == LVL_ID) ? lvl1 : 1'b0;
    irq_edge_sync #(.RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(raw[g]), .rise_sel_i(rsel),
      .low_o(low[g]), .edge_o(edge_ev[g])
    );
  end

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_ev), .low_i(low),
    .lvl_mode_i(lvl_mode), .gen_i(gen), .ack_i(ack_i), .reti_i(reti_i),
    .irq_o(irq_o), .vec_id_o(vec_id_o), .vec_addr_o(vec_addr_o),
    .in_service_o(in_service_o), .nmi_active_o(nmi_active_o), .take_o(take)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_o,
  input logic [2:0]  vec_id_o,
  input logic [11:0] vec_addr_o,
  input logic        ack_i,
  input logic        reti_i,
  input logic        take,
  input logic        gen,
  input logic        in_service_o,
  input logic        nmi_active_o
);
  a_r5_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && vec_id_o != 3'd0) |-> (!in_service_o && !nmi_active_o));

  a_r4_gen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && vec_id_o != 3'd0) |-> gen);

  a_r6_nmi_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_id_o == 3'd0) |=> nmi_active_o);

  a_r6_no_reenter: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_active_o |-> !(irq_o && vec_id_o == 3'd0));

  a_r6_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && nmi_active_o && !take) |=>
      (!nmi_active_o && in_service_o == $past(in_service_o)));

  a_r10_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_id_o != 3'd0) |=> in_service_o);

  a_r10_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !reti_i) |=>
      (in_service_o == $past(in_service_o) && nmi_active_o == $past(nmi_active_o)));

  a_r2_vec_slot: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_addr_o[11:4] == 8'hFF && !vec_addr_o[0]));

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_addr_o == 12'h000 && vec_id_o == 3'd0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .vec_id_o(vec_id_o),
  .vec_addr_o(vec_addr_o), .ack_i(ack_i), .reti_i(reti_i), .take(take),
  .gen(gen), .in_service_o(in_service_o), .nmi_active_o(nmi_active_o)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] drv = 5'b11111;  // bit k drives source id k
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00;
  logic ack = 1'b0, reti = 1'b0;
  logic irq, in_svc, nmi_act;
  logic [2:0] vid;
  logic [11:0] vaddr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_n_i(drv[0]), .tmr2_n_i(drv[1]),
    .vsync_i(drv[2]), .tmr1_n_i(drv[3]), .pwr_n_i(drv[4]),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_id_o(vid),
    .vec_addr_o(vaddr), .in_service_o(in_svc), .nmi_active_o(nmi_act)
  );

  function automatic logic [11:0] exp_addr(input int id);
    case (id)
      0: return 12'hFFC;
      1: return 12'hFF6;
      2: return 12'hFF4;
      3: return 12'hFF2;
      4: return 12'hFF0;
      default: return 12'h000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_opt(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc(1);
    cfg_we = 1'b0;
    cyc(1);
  endtask

  task automatic pulse(input logic [4:0] m);
    drv = drv & ~m;
    cyc(3);
    drv = 5'b11111;
    cyc(5);
  endtask

  task automatic take;
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic ret;
    reti = 1'b1; cyc(1); reti = 1'b0;
  endtask

  // accept and return every presented request; checks strict order
  task automatic drain(input string req, input int exp_n);
    int n = 0;
    int last = -1;
    for (int k = 0; k < 8 && irq; k++) begin
      chk(req, {31'd0, (int'(vid) > last)}, 32'd1);
      chk(req, {20'd0, vaddr}, {20'd0, exp_addr(int'(vid))});
      last = int'(vid);
      take; ret;
      n++;
    end
    chk(req, n, exp_n);
    chk(req, {31'd0, irq}, 32'd0);
  endtask

  typedef struct packed { logic [7:0] opt; logic [4:0] mask; logic [2:0] id; } vec_t;
  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{8'h40, 5'b11110, 3'd1},
    '{8'h40, 5'b11100, 3'd2},
    '{8'h40, 5'b11000, 3'd3},
    '{8'h40, 5'b10000, 3'd4},
    '{8'h40, 5'b10100, 3'd2},
    '{8'h40, 5'b11111, 3'd0},
    '{8'h50, 5'b01000, 3'd3},
    '{8'h40, 5'b00010, 3'd1}
  };

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 svc", {31'd0, in_svc}, 0);
    chk("R1 nmi", {31'd0, nmi_act}, 0);
    chk("R2 idle addr", {20'd0, vaddr}, 0);
    // R1/R4 blocked at reset, but pending latched
    pulse(5'b01000);
    chk("R1 gen off", {31'd0, irq}, 0);
    wr_opt(8'hC8, 8'h40);
    chk("R4 pend kept", {29'd0, vid}, 3);
    chk("R11 one event", {31'd0, irq}, 1);
    drain("R11 drain", 1);

    // table: R2 R3 R8 R10 R11
    foreach (TBL[i]) begin
      wr_opt(8'hC8, TBL[i].opt);
      pulse(TBL[i].mask);
      chk("R3 irq", {31'd0, irq}, 1);
      chk("R3 winner", {29'd0, vid}, {29'd0, TBL[i].id});
      chk("R2 addr", {20'd0, vaddr}, {20'd0, exp_addr(int'(TBL[i].id))});
      drain("R10 drain", $countones(TBL[i].mask));
    end

    // R4 NMI accepted with enable off
    wr_opt(8'hC8, 8'h00);
    pulse(5'b00011);
    chk("R4 nmi", {31'd0, irq}, 1);
    chk("R4 nmi id", {29'd0, vid}, 0);
    take; ret;
    chk("R4 masked", {31'd0, irq}, 0);
    wr_opt(8'hC8, 8'h40);
    drain("R4 drain", 1);

    // R9 other address ignored, unused bits ignored
    wr_opt(8'hC9, 8'h00);
    pulse(5'b00010);
    chk("R9 addr", {31'd0, irq}, 1);
    drain("R9 drain", 1);
    wr_opt(8'hC8, 8'hBF);
    pulse(5'b00010);
    chk("R9 unused", {31'd0, irq}, 0);
    wr_opt(8'hC8, 8'h40);
    drain("R9 drain2", 1);

    // R10 ack with no request
    take;
    chk("R10 idle ack", {31'd0, in_svc}, 0);

    // R5 R6 nesting
    pulse(5'b01000);
    take;
    chk("R5 svc", {31'd0, in_svc}, 1);
    pulse(5'b00010);
    chk("R5 no nest", {31'd0, irq}, 0);
    pulse(5'b00001);
    chk("R6 preempt", {31'd0, irq}, 1);
    chk("R6 id", {29'd0, vid}, 0);
    take;
    chk("R6 active", {31'd0, nmi_act}, 1);
    pulse(5'b00001);
    chk("R6 no reenter", {31'd0, irq}, 0);
    ret;
    chk("R6 nmi again", {29'd0, vid}, 0);
    chk("R6 nmi again irq", {31'd0, irq}, 1);
    take; ret;
    chk("R6 restore", {31'd0, in_svc}, 1);
    chk("R6 cleared", {31'd0, nmi_act}, 0);
    chk("R5 still held", {31'd0, irq}, 0);
    ret;
    chk("R5 released", {31'd0, in_svc}, 0);
    drain("R5 drain", 1);

    // R7 level mode
    wr_opt(8'hC8, 8'h60);
    drv[1] = 1'b0;
    cyc(4);
    chk("R7 level", {29'd0, vid}, 1);
    chk("R7 level irq", {31'd0, irq}, 1);
    take; ret;
    chk("R7 resample", {31'd0, irq}, 1);
    take;
    drv[1] = 1'b1;
    cyc(4);
    ret;
    chk("R7 not latched", {31'd0, irq}, 0);
    // R7 edge mode, held low gives one request
    wr_opt(8'hC8, 8'h40);
    drv[1] = 1'b0;
    cyc(4);
    take; ret;
    cyc(3);
    chk("R7 edge once", {31'd0, irq}, 0);
    drv[1] = 1'b1;
    cyc(4);

    // R8 rising select ignores falling change
    wr_opt(8'hC8, 8'h50);
    drv[2] = 1'b0;
    cyc(6);
    chk("R8 fall ignored", {31'd0, irq}, 0);
    drv[2] = 1'b1;
    cyc(4);
    chk("R8 rise", {29'd0, vid}, 2);
    drain("R8 drain", 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule